// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides its input clock by a programmable ratio N = P*SM + SS and marks the end of every division cycle with a single-clock output pulse. P is the modulus of a dual-modulus prescaler, SM is the main count and SS is the swallow count. The prescaler runs P+1 clocks per period while swallow periods remain. After that it runs P clocks per period until the main count is used up. Then both counts reload and a new cycle begins.

A build parameter selects the prescaler variant: P = 64 with a 6-bit swallow count, or P = 8 with a 3-bit swallow count. The main count is 11 bits in both variants. New settings are presented on the count inputs and captured by a one-clock load strobe. They take effect only at a cycle boundary, so a running cycle is never cut short or stretched. Illegal pairs are clamped to the nearest legal setting, and a sticky flag records that the clamp was used.

Top module: `swallow_divider`

## Requirements
- R1: Consecutive pulses on `div_out` are exactly P*SM + SS clocks apart. P is 64 and `swallow_cnt` is 6 bits when `PRESCALE_WIDE` is 1; P is 8 and `swallow_cnt` is 3 bits when it is 0.
- R2: `div_out` is high for exactly one clock per division cycle, and that clock is the last clock of the cycle.
- R3: Within a cycle, the first SS prescaler periods last P+1 clocks and the remaining SM-SS periods last P clocks. With SS = 0 the cycle is exactly P*SM clocks.
- R4: A load strobe in a clock other than the pulse clock leaves the length of the running cycle unchanged. The captured setting governs the following cycle.
- R5: A load strobe in the same clock as the pulse takes effect for the cycle that starts on the next clock.
- R6: When several strobes fall within one cycle, the last one decides the next cycle.
- R7: A captured main count below 5 is used as 5.
- R8: A captured swallow count that is not below the main count (after R7) is used as the main count minus 1.
- R9: `cfg_err` rises on the clock after a strobe whose raw pair is illegal (SM < 5 or SS >= SM). It then stays high until reset. Strobes with legal pairs never raise it.
- R10: Reset is synchronous and active low. During reset `div_out` and `cfg_err` are low. The settings present at the last reset clock, clamped as in R7/R8 and without raising `cfg_err`, define the first cycle. The first pulse arrives on the N-th clock after reset is released.
- R11: Changes on `main_cnt` or `swallow_cnt` without a strobe have no effect on the division ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | One-clock strobe that captures the count inputs |
| main_cnt | input | 11 | Main count SM, legal range 5..2047 |
| swallow_cnt | input | 6 (3 when PRESCALE_WIDE=0) | Swallow count SS, must be below SM |
| div_out | output | 1 | One-clock pulse at the end of every division cycle |
| cfg_err | output | 1 | Sticky flag: an illegal pair was clamped |

## Verification
The critical coincidence is a load strobe in the same clock as the terminal pulse, where capture and counter reload happen together. The bench waits until it sees the pulse and raises the strobe in that very clock. It then expects the new ratio for the cycle that starts at once, not one cycle later. The opposite case, a strobe in the middle of a cycle, is judged against the unchanged old ratio for the running cycle. A scoreboard compares every measured pulse interval against the queued ratio for that cycle.

// File: rtl/swdiv_pkg.sv
// Shared definitions for the pulse-swallow divider.
// Assumes: the main count is 11 bits wide in every variant; swallow counts are
// carried internally at the same width so that comparisons need no resizing.
package swdiv_pkg;

    localparam int SM_W   = 11;
    localparam int SM_MIN = 5;

    // One complete division setting as used by the counters.
    typedef struct packed {
        logic [SM_W-1:0] sm;
        logic [SM_W-1:0] ss;
    } div_cfg_t;

    // Raise a main count below the minimum to the minimum.
    function automatic logic [SM_W-1:0] clamp_main(input logic [SM_W-1:0] sm);
        return (sm < SM_W'(SM_MIN)) ? SM_W'(SM_MIN) : sm;
    endfunction

    // Keep a swallow count strictly below an already legal main count.
    function automatic logic [SM_W-1:0] clamp_swallow(input logic [SM_W-1:0] ss,
                                                      input logic [SM_W-1:0] sm);
        return (ss >= sm) ? (sm - SM_W'(1)) : ss;
    endfunction

endpackage

// File: rtl/swdiv_prescaler.sv
// Dual-modulus prescaler: a down-counter that spans P+1 clocks per period when
// long_next is high at reload time, else P clocks. pre_tc marks the final
// clock of each period.
// Assumes: long_next is valid in every clock where the counter reloads.
module swdiv_prescaler #(
    parameter int P = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic long_next,
    output logic pre_tc
);

    localparam int PC_W = $clog2(P + 1);

    logic [PC_W-1:0] pc;

    // Terminal clock of the current prescaler period.
    assign pre_tc = (pc == '0);

    // Count down; reload with P (P+1 clocks) or P-1 (P clocks) at zero or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || pc == '0) begin
            pc <= long_next ? PC_W'(P) : PC_W'(P - 1);
        end else begin
            pc <= pc - 1'b1;
        end
    end

    // R3: between reloads the counter steps down by exactly one per clock.
    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (pc != '0) |=> (pc == $past(pc) - 1'b1));

    // R3: a reload picks one of the two legal moduli.
    a_r3_reload_modulus: assert property (@(posedge clk) disable iff (!rst_n)
        (pc == '0) |=> (pc == PC_W'(P) || pc == PC_W'(P - 1)));

endmodule

// File: rtl/swdiv_cfg.sv
// Settings manager: clamps incoming counts, holds a pending setting captured by
// the load strobe, and hands the counters the setting to use at the next
// reload. Also keeps the sticky illegal-setting flag.
// Assumes: boundary is high only in the last clock of a division cycle.
module swdiv_cfg
    import swdiv_pkg::*;
#(
    parameter int SS_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic [SM_W-1:0] sm_in,
    input  logic [SS_W-1:0] ss_in,
    input  logic            boundary,
    output div_cfg_t        sel,
    output logic            cfg_err
);

    logic [SM_W-1:0] ss_ext;
    logic            raw_illegal;
    div_cfg_t        clamped;
    div_cfg_t        pend;
    div_cfg_t        active;
    logic            pend_v;

    // Clamp the inputs and judge the raw pair.
    always_comb begin
        ss_ext      = SM_W'(ss_in);
        raw_illegal = (sm_in < SM_W'(SM_MIN)) || (ss_ext >= sm_in);
        clamped.sm  = clamp_main(sm_in);
        clamped.ss  = clamp_swallow(ss_ext, clamped.sm);
    end

    // Setting for the next reload: live inputs under reset or strobe, else pending, else current.
    always_comb begin
        if (!rst_n || load_en) begin
            sel = clamped;
        end else if (pend_v) begin
            sel = pend;
        end else begin
            sel = active;
        end
    end

    // Capture strobed settings and commit them at the cycle boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= sel;
            pend   <= '0;
            pend_v <= 1'b0;
        end else if (boundary) begin
            active <= sel;
            pend_v <= 1'b0;
        end else if (load_en) begin
            pend   <= clamped;
            pend_v <= 1'b1;
        end
    end

    // Sticky flag set by any strobe of an illegal pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else if (load_en && raw_illegal) begin
            cfg_err <= 1'b1;
        end
    end

    // R9: once raised, the flag holds until reset.
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R7: the committed main count is never below the minimum.
    a_r7_active_main_legal: assert property (@(posedge clk) disable iff (!rst_n)
        active.sm >= SM_W'(SM_MIN));

    // R8: the committed swallow count is always below the committed main count.
    a_r8_active_swallow_legal: assert property (@(posedge clk) disable iff (!rst_n)
        active.ss < active.sm);

endmodule

// File: rtl/swdiv_sequencer.sv
// Main and swallow counters. Each prescaler period decrements the main count
// and, while nonzero, the swallow count. The last period of a cycle raises
// boundary for one clock, and both counts reload from the selected setting.
// Assumes: sel.ss < sel.sm and sel.sm >= 5 (guaranteed by swdiv_cfg).
module swdiv_sequencer
    import swdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pre_tc,
    input  div_cfg_t sel,
    output logic     boundary,
    output logic     long_next
);

    logic [SM_W-1:0] mc;
    logic [SM_W-1:0] sw;
    logic [SM_W-1:0] sw_nxt;

    // The final prescaler clock of the last main-count period ends the cycle.
    assign boundary = pre_tc && (mc == SM_W'(1));

    // Next swallow count, used by the prescaler to choose its next modulus.
    always_comb begin
        if (!rst_n || boundary) begin
            sw_nxt = sel.ss;
        end else if (pre_tc && sw != '0) begin
            sw_nxt = sw - SM_W'(1);
        end else begin
            sw_nxt = sw;
        end
        long_next = (sw_nxt != '0);
    end

    // Swallow counter follows its next value.
    always_ff @(posedge clk) begin
        sw <= sw_nxt;
    end

    // Main counter: reload at reset or boundary, step once per prescaler period.
    always_ff @(posedge clk) begin
        if (!rst_n || boundary) begin
            mc <= sel.sm;
        end else if (pre_tc) begin
            mc <= mc - SM_W'(1);
        end
    end

    // R2: the output pulse never lasts two clocks.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> !boundary);

    // R4: a new cycle starts from the setting offered by the settings manager.
    a_r4_reload_from_sel: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (mc == $past(sel.sm)));

    // R3: swallow periods are used up before the last main period.
    a_r3_swallow_below_main: assert property (@(posedge clk) disable iff (!rst_n)
        sw < mc);

    // R1: the main count never reaches zero.
    a_r1_main_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        mc != '0);

endmodule

// File: rtl/swallow_divider.sv
// Pulse-swallow programmable divider top. One div_out pulse every
// P*SM + SS clocks, with P picked by PRESCALE_WIDE.
// Assumes: load_en is a clean synchronous strobe; counts are sampled with it.
module swallow_divider
    import swdiv_pkg::*;
#(
    parameter bit PRESCALE_WIDE = 1'b1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  load_en,
    input  logic [SM_W-1:0]                       main_cnt,
    input  logic [(PRESCALE_WIDE ? 6 : 3)-1:0]    swallow_cnt,
    output logic                                  div_out,
    output logic                                  cfg_err
);

    localparam int P    = PRESCALE_WIDE ? 64 : 8;
    localparam int SS_W = PRESCALE_WIDE ? 6 : 3;

    div_cfg_t sel;
    logic     pre_tc;
    logic     long_next;
    logic     boundary;

    swdiv_cfg #(.SS_W(SS_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .sm_in    (main_cnt),
        .ss_in    (swallow_cnt),
        .boundary (boundary),
        .sel      (sel),
        .cfg_err  (cfg_err)
    );

    swdiv_prescaler #(.P(P)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .long_next (long_next),
        .pre_tc    (pre_tc)
    );

    swdiv_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_tc    (pre_tc),
        .sel       (sel),
        .boundary  (boundary),
        .long_next (long_next)
    );

    assign div_out = boundary;

    // R10: no pulse or error is visible in the clock after a reset edge.
    a_r10_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!div_out && !cfg_err));

endmodule

// File: tb/swallow_divider_bench.sv
`timescale 1ns/1ps
module swallow_divider_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [10:0] main_cnt = 11'd6;
    logic [5:0]  swallow_cnt = 6'd3;
    logic        div_out;
    logic        cfg_err;

    int n_checks = 0;
    int n_fail = 0;
    int exp_q[$];
    string tag_q[$];
    int idx = 0;
    int last = -1;
    bit prev_hi = 1'b0;

    always #2 clk = ~clk;

    swallow_divider u_swallow_divider (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en     (load_en),
        .main_cnt    (main_cnt),
        .swallow_cnt (swallow_cnt),
        .div_out     (div_out),
        .cfg_err     (cfg_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push_exp(input int n, input string tag);
        exp_q.push_back(n);
        tag_q.push_back(tag);
    endtask

    // Driver grid: one step lands just after a rising edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_pulse();
        do step(); while (!div_out);
    endtask

    task automatic strobe(input int sm, input int ss);
        main_cnt = 11'(sm);
        swallow_cnt = 6'(ss);
        load_en = 1'b1;
        step();
        load_en = 1'b0;
    endtask

    // Monitor: measures pulse intervals and compares them with the scoreboard.
    always @(negedge clk) begin
        if (!rst_n) begin
            idx = 0;
            last = -1;
            prev_hi = 1'b0;
        end else begin
            if (div_out) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected pulse", idx - last, 0);
                end else begin
                    check((idx - last) == exp_q[0], tag_q[0], idx - last, exp_q[0]);
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end
                check(!prev_hi, "R2 pulse width", 2, 1);
                last = idx;
            end
            prev_hi = div_out;
            idx++;
        end
    end

    initial begin
        push_exp(387, "R10 first cycle after reset");
        repeat (3) step();
        check(!div_out, "R10 div_out in reset", int'(div_out), 0);
        check(!cfg_err, "R10 cfg_err in reset", int'(cfg_err), 0);
        rst_n = 1'b1;

        wait_pulse();
        push_exp(387, "R1 steady ratio");
        repeat (5) step();
        main_cnt = 11'd20;
        swallow_cnt = 6'd10;

        wait_pulse();
        push_exp(387, "R11 inputs ignored without strobe");
        repeat (20) step();
        strobe(9, 0);

        wait_pulse();
        push_exp(576, "R3 zero swallow gives P*SM");
        check(!cfg_err, "R9 legal strobe leaves flag", int'(cfg_err), 0);

        wait_pulse();
        push_exp(454, "R5 strobe in pulse clock");
        strobe(7, 6);

        wait_pulse();
        push_exp(454, "R4 mid-cycle strobe keeps running cycle");
        repeat (10) step();
        strobe(10, 2);
        repeat (10) step();
        strobe(5, 4);

        wait_pulse();
        push_exp(324, "R6 last strobe wins");
        check(!cfg_err, "R9 boundary legal pair", int'(cfg_err), 0);

        wait_pulse();
        push_exp(324, "R1 steady after change");
        repeat (5) step();
        strobe(3, 1);
        check(cfg_err, "R9 illegal main raises flag", int'(cfg_err), 1);

        wait_pulse();
        push_exp(321, "R7 main clamped to 5");

        wait_pulse();
        push_exp(321, "R7 steady clamped");
        step();
        strobe(6, 6);
        check(cfg_err, "R9 flag stays high", int'(cfg_err), 1);

        wait_pulse();
        push_exp(389, "R8 swallow clamped below main");

        wait_pulse();
        push_exp(389, "R8 steady clamped");
        repeat (3) step();
        rst_n = 1'b0;
        exp_q.delete();
        tag_q.delete();
        main_cnt = 11'd2;
        swallow_cnt = 6'd50;
        push_exp(324, "R10 reset with clamped settings");
        repeat (3) step();
        check(!cfg_err, "R10 reset clears flag", int'(cfg_err), 0);
        rst_n = 1'b1;

        wait_pulse();
        check(!cfg_err, "R10 clamp at reset leaves flag low", int'(cfg_err), 0);
        push_exp(324, "R1 steady after reset");
        wait_pulse();
        repeat (3) step();
        check(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R1 watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule